// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged 64-bit control registers of a processor core behind a single-cycle read/write port. An access names a register through a 6-bit index. Read data and the fault flag come back combinationally in the same cycle as the request. A write takes effect at the next clock edge. Every index has its own policy:

- full-width storage;
- storage through a bit mask;
- clear on any write;
- write once;
- read-only or write-only, with a fault raised for the wrong direction;
- a command toward the translation buffers.

Writes to the translation-buffer control indices produce registered one-cycle command pulses. These pulses are invalidate all, invalidate by process, invalidate one address, and fill one entry. A fill is built from a staged page-table-entry register and the current address-space number. A read of the cycle counter merges stored upper bits with a free-running tick. The translation buffers, the interrupt logic and the pipeline lie outside the block. They see only the pulses and the fields that travel with them.

Top module: `ctl_reg_bank`

## Requirements
- R1: After reset every register holds zero, every readable index reads zero and no command or error pulse is high.
- R2: Scratch indices 0 to 23 and the vector-base index 24 store all 64 written bits. A read returns the stored value in the same cycle as the request, with acc_fault low.
- R3: Masked indices keep only these bits on a write: AST request (26) and AST enable (27) keep bits 3:0; interrupt level (28) keeps bits 4:0; instruction mode (29), data mode (30) and alternate mode (31) keep mask 0x18; software interrupt request (32) keeps mask 0x7FFF0; data ASN (49) keeps bits 63:57; instruction ASN (50) keeps bits 10:4.
- R4: The exception-address index 25 stores the written value with bit 1 forced to zero.
- R5: The exception-summary index 33 and the exception-mask index 34 become zero on any write, whatever the data.
- R6: A write to the read-only indices 37 (interrupt id) or 38 (memory-management status) raises acc_fault and leaves the register unchanged.
- R7: A read of a write-only index (31, 36, 39 to 48, 52) raises acc_fault and returns zero. Indices 53 to 63 fault in both directions. A faulting read always returns zero.
- R8: A read of the cycle-counter index 35 returns stored bits 63:32 and, in bits 31:0, a tick count that advances by one every clock after reset.
- R9: The first write to the cycle-control index 36 after reset sets it to 1 without error. Each later write raises cc_ctl_err for one cycle.
- R10: A write to index 43 (data invalidate all), 44 (data invalidate by process), 46 (instruction invalidate all) or 47 (instruction invalidate by process) raises only the matching pulse. The pulse is high for exactly the one cycle after the write.
- R11: A write to index 45 raises dtb_inv_addr and a write to index 48 raises itb_inv_addr. Either pulse comes with inv_va equal to the written data. inv_asn is the ASN field of that side: bits 63:57 of index 49 for data, bits 10:4 of index 50 for instruction.
- R12: The staged data-PTE index 51 stores all bits. A read returns them ANDed with 0xFFFFFFFF0000FF16. The fields are PPN at 58:32, ASN at 63:57, write enables at 15:12, read enables at 11:8, ASM at bit 4, fault-on-write at bit 2 and fault-on-read at bit 1.
- R13: A write to the data-tag index 52 behaves in one of two ways, chosen by staged PTE bits 6:5. If those bits are zero, it pulses dtb_fill with fill_tag equal to the data and fill_pte = (staged & 0x07FFFFFF0000FF16) | (data ASN << 57). Otherwise it pulses fill_hint_err and issues no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 6 | Register index |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, same cycle, zero on fault |
| acc_fault | output | 1 | Illegal access this cycle |
| dtb_inv_all | output | 1 | Data TLB invalidate-all pulse |
| dtb_inv_proc | output | 1 | Data TLB invalidate-by-process pulse |
| dtb_inv_addr | output | 1 | Data TLB single-address invalidate pulse |
| itb_inv_all | output | 1 | Instruction TLB invalidate-all pulse |
| itb_inv_proc | output | 1 | Instruction TLB invalidate-by-process pulse |
| itb_inv_addr | output | 1 | Instruction TLB single-address invalidate pulse |
| inv_va | output | 64 | Address for a single-address invalidate |
| inv_asn | output | 7 | ASN for a single-address invalidate |
| dtb_fill | output | 1 | Data TLB fill pulse |
| fill_tag | output | 64 | Tag of the fill |
| fill_pte | output | 64 | Packed entry of the fill |
| fill_hint_err | output | 1 | Fill refused: nonzero granularity hint |
| cc_ctl_err | output | 1 | Repeated cycle-control write |

## Verification
The bench sweeps every index with all-ones, both alternating patterns and seeded random data. It compares each read against a bench model of the masks. This exposes a wrong mask, a lost bit-1 clear on the exception address, or a clear-on-write register that keeps data. It also catches a read-only register that accepts a write, or a write-only register that leaks its contents.

Directed cases aim at the command side. A stale or wrong-side ASN on a single-address invalidate would show up, as would a pulse that lasts two cycles or fires on its neighbour. A fill issued despite a nonzero hint field, or built from the wrong field mask, is also covered. So is a cycle-control register that does not flag a repeated write. The tick check compares two counter reads against elapsed time, which reveals a counter that stalls or skips.

// File: rtl/crb_pkg.sv
// Shared constants for the control register bank: index map, masks, widths.
// Assumes a 6-bit index space; indices not named here are illegal.
package crb_pkg;
    localparam int IDX_W    = 6;
    localparam int DATA_W   = 64;
    localparam int NUM_IDX  = 1 << IDX_W;
    localparam int NUM_TEMP = 24;
    localparam int ASN_W    = 7;

    localparam logic [IDX_W-1:0] R_VBASE     = 6'd24;
    localparam logic [IDX_W-1:0] R_EXC_ADDR  = 6'd25;
    localparam logic [IDX_W-1:0] R_AST_REQ   = 6'd26;
    localparam logic [IDX_W-1:0] R_AST_EN    = 6'd27;
    localparam logic [IDX_W-1:0] R_IPL       = 6'd28;
    localparam logic [IDX_W-1:0] R_IMODE     = 6'd29;
    localparam logic [IDX_W-1:0] R_DMODE     = 6'd30;
    localparam logic [IDX_W-1:0] R_ALTMODE   = 6'd31;
    localparam logic [IDX_W-1:0] R_SWINT     = 6'd32;
    localparam logic [IDX_W-1:0] R_EXC_SUM   = 6'd33;
    localparam logic [IDX_W-1:0] R_EXC_MASK  = 6'd34;
    localparam logic [IDX_W-1:0] R_CYC_CNT   = 6'd35;
    localparam logic [IDX_W-1:0] R_CYC_CTL   = 6'd36;
    localparam logic [IDX_W-1:0] R_INT_ID    = 6'd37;
    localparam logic [IDX_W-1:0] R_MM_STAT   = 6'd38;
    localparam logic [IDX_W-1:0] R_HWINT_CLR = 6'd39;
    localparam logic [IDX_W-1:0] R_SER_TX    = 6'd40;
    localparam logic [IDX_W-1:0] R_DFLUSH    = 6'd41;
    localparam logic [IDX_W-1:0] R_IFLUSH    = 6'd42;
    localparam logic [IDX_W-1:0] R_DINV_ALL  = 6'd43;
    localparam logic [IDX_W-1:0] R_DINV_PROC = 6'd44;
    localparam logic [IDX_W-1:0] R_DINV_ONE  = 6'd45;
    localparam logic [IDX_W-1:0] R_IINV_ALL  = 6'd46;
    localparam logic [IDX_W-1:0] R_IINV_PROC = 6'd47;
    localparam logic [IDX_W-1:0] R_IINV_ONE  = 6'd48;
    localparam logic [IDX_W-1:0] R_DASN      = 6'd49;
    localparam logic [IDX_W-1:0] R_IASN      = 6'd50;
    localparam logic [IDX_W-1:0] R_DPTE      = 6'd51;
    localparam logic [IDX_W-1:0] R_DTAG      = 6'd52;

    localparam logic [DATA_W-1:0] M_DASN     = 64'hFE00_0000_0000_0000;
    localparam logic [DATA_W-1:0] M_IASN     = 64'h0000_0000_0000_07F0;
    localparam logic [DATA_W-1:0] M_PTE_VIEW = 64'hFFFF_FFFF_0000_FF16;
    localparam logic [DATA_W-1:0] M_PTE_FILL = 64'h07FF_FFFF_0000_FF16;
    localparam int               DASN_LSB   = 57;
    localparam int               IASN_LSB   = 4;
    localparam int               HINT_LSB   = 5;
endpackage

// File: rtl/crb_access_decode.sv
// Access policy decode: for one index, says whether a read or a write is
// legal and what value a write stores. Purely combinational; assumes the
// caller gates everything with the request valid.
module crb_access_decode
    import crb_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic [DATA_W-1:0] wr_value
);
    // Per-index read legality, write legality and stored value.
    always_comb begin
        rd_ok    = 1'b0;
        wr_ok    = 1'b1;
        wr_value = wdata;
        if (int'(idx) < NUM_TEMP) begin
            rd_ok = 1'b1;
        end else begin
            case (idx)
                R_VBASE, R_CYC_CNT, R_DPTE: rd_ok = 1'b1;
                R_EXC_ADDR: begin rd_ok = 1'b1; wr_value = wdata & ~64'h2; end
                R_AST_REQ, R_AST_EN: begin rd_ok = 1'b1; wr_value = wdata & 64'hF; end
                R_IPL: begin rd_ok = 1'b1; wr_value = wdata & 64'h1F; end
                R_IMODE, R_DMODE: begin rd_ok = 1'b1; wr_value = wdata & 64'h18; end
                R_ALTMODE: wr_value = wdata & 64'h18;
                R_SWINT: begin rd_ok = 1'b1; wr_value = wdata & 64'h7FFF0; end
                R_EXC_SUM, R_EXC_MASK: begin rd_ok = 1'b1; wr_value = '0; end
                R_CYC_CTL: wr_value = 64'd1;
                R_INT_ID, R_MM_STAT: begin rd_ok = 1'b1; wr_ok = 1'b0; end
                R_HWINT_CLR, R_SER_TX, R_DFLUSH, R_IFLUSH,
                R_DINV_ONE, R_IINV_ONE, R_DTAG: wr_value = wdata;
                R_DINV_ALL, R_DINV_PROC, R_IINV_ALL, R_IINV_PROC: wr_value = '0;
                R_DASN: begin rd_ok = 1'b1; wr_value = wdata & M_DASN; end
                R_IASN: begin rd_ok = 1'b1; wr_value = wdata & M_IASN; end
                default: wr_ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/crb_tick.sv
// Free-running tick counter feeding the low half of the cycle-counter read.
// Clears on synchronous reset, wraps silently.
module crb_tick #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Advance by one every clock outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    p_tick_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/crb_tlb_cmd.sv
// Turns accepted writes to translation-buffer control indices into
// registered one-cycle command pulses with their side-band fields.
// Assumes `fire` is already qualified by a legal write.
module crb_tlb_cmd
    import crb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ASN_W-1:0]  dasn,
    input  logic [ASN_W-1:0]  iasn,
    input  logic [DATA_W-1:0] staged_pte,
    output logic              dtb_inv_all,
    output logic              dtb_inv_proc,
    output logic              dtb_inv_addr,
    output logic              itb_inv_all,
    output logic              itb_inv_proc,
    output logic              itb_inv_addr,
    output logic [DATA_W-1:0] inv_va,
    output logic [ASN_W-1:0]  inv_asn,
    output logic              dtb_fill,
    output logic [DATA_W-1:0] fill_tag,
    output logic [DATA_W-1:0] fill_pte,
    output logic              fill_hint_err
);
    logic hint_bad;
    assign hint_bad = |staged_pte[HINT_LSB+1:HINT_LSB];

    // Register one pulse per accepted command write, plus its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {dtb_inv_all, dtb_inv_proc, dtb_inv_addr}  <= '0;
            {itb_inv_all, itb_inv_proc, itb_inv_addr}  <= '0;
            {dtb_fill, fill_hint_err}                  <= '0;
            inv_va   <= '0;
            inv_asn  <= '0;
            fill_tag <= '0;
            fill_pte <= '0;
        end else begin
            dtb_inv_all   <= fire && idx == R_DINV_ALL;
            dtb_inv_proc  <= fire && idx == R_DINV_PROC;
            dtb_inv_addr  <= fire && idx == R_DINV_ONE;
            itb_inv_all   <= fire && idx == R_IINV_ALL;
            itb_inv_proc  <= fire && idx == R_IINV_PROC;
            itb_inv_addr  <= fire && idx == R_IINV_ONE;
            dtb_fill      <= fire && idx == R_DTAG && !hint_bad;
            fill_hint_err <= fire && idx == R_DTAG && hint_bad;
            if (fire && idx == R_DINV_ONE) begin
                inv_va  <= wdata;
                inv_asn <= dasn;
            end
            if (fire && idx == R_IINV_ONE) begin
                inv_va  <= wdata;
                inv_asn <= iasn;
            end
            if (fire && idx == R_DTAG) begin
                fill_tag <= wdata;
                fill_pte <= (staged_pte & M_PTE_FILL) | ({{(DATA_W-ASN_W){1'b0}}, dasn} << DASN_LSB);
            end
        end
    end

    p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dtb_inv_all, dtb_inv_proc, dtb_inv_addr,
                  itb_inv_all, itb_inv_proc, itb_inv_addr, dtb_fill, fill_hint_err}));
    p_cmd_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dtb_inv_all |=> !dtb_inv_all || $past(fire && idx == R_DINV_ALL));
endmodule

// File: rtl/ctl_reg_bank.sv
// Privileged control register bank. Single-cycle port: read data and fault
// are combinational, writes land at the clock edge. Per-index policy comes
// from crb_access_decode; translation-buffer commands from crb_tlb_cmd.
// Assumes one access per cycle and a synchronous active-low reset.
module ctl_reg_bank
    import crb_pkg::*;
#(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [5:0]        acc_idx,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata,
    output logic              acc_fault,
    output logic              dtb_inv_all,
    output logic              dtb_inv_proc,
    output logic              dtb_inv_addr,
    output logic              itb_inv_all,
    output logic              itb_inv_proc,
    output logic              itb_inv_addr,
    output logic [63:0]       inv_va,
    output logic [6:0]        inv_asn,
    output logic              dtb_fill,
    output logic [63:0]       fill_tag,
    output logic [63:0]       fill_pte,
    output logic              fill_hint_err,
    output logic              cc_ctl_err
);
    localparam int LOW_W = (TICK_W < 32) ? TICK_W : 32;

    logic [DATA_W-1:0] regs [NUM_IDX];
    logic              rd_ok, wr_ok, wr_fire;
    logic [DATA_W-1:0] wr_value, view;
    logic [TICK_W-1:0] tick;

    crb_access_decode u_dec (
        .idx(acc_idx), .wdata(acc_wdata),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .wr_value(wr_value)
    );

    crb_tick #(.W(TICK_W)) u_tick (.clk(clk), .rst_n(rst_n), .cnt(tick));

    assign wr_fire = acc_valid && acc_write && wr_ok;

    // Store the policy-shaped write value into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDX; i++) regs[i] <= '0;
        end else if (wr_fire) begin
            regs[acc_idx] <= wr_value;
        end
    end

    // Flag a cycle-control write that finds the register already set.
    always_ff @(posedge clk) begin
        if (!rst_n) cc_ctl_err <= 1'b0;
        else        cc_ctl_err <= wr_fire && acc_idx == R_CYC_CTL && regs[R_CYC_CTL] != '0;
    end

    // Shape the stored value for reading: counter merge and PTE packing.
    always_comb begin
        view = regs[acc_idx];
        if (acc_idx == R_CYC_CNT) begin
            view[31:0] = '0;
            view[LOW_W-1:0] = tick[LOW_W-1:0];
        end else if (acc_idx == R_DPTE) begin
            view = regs[acc_idx] & M_PTE_VIEW;
        end
    end

    // Gate read data and raise the fault for the illegal direction.
    always_comb begin
        acc_rdata = (acc_valid && !acc_write && rd_ok) ? view : '0;
        acc_fault = acc_valid && (acc_write ? !wr_ok : !rd_ok);
    end

    crb_tlb_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .fire(wr_fire), .idx(acc_idx), .wdata(acc_wdata),
        .dasn(regs[R_DASN][DASN_LSB +: ASN_W]), .iasn(regs[R_IASN][IASN_LSB +: ASN_W]),
        .staged_pte(regs[R_DPTE]),
        .dtb_inv_all(dtb_inv_all), .dtb_inv_proc(dtb_inv_proc), .dtb_inv_addr(dtb_inv_addr),
        .itb_inv_all(itb_inv_all), .itb_inv_proc(itb_inv_proc), .itb_inv_addr(itb_inv_addr),
        .inv_va(inv_va), .inv_asn(inv_asn), .dtb_fill(dtb_fill), .fill_tag(fill_tag),
        .fill_pte(fill_pte), .fill_hint_err(fill_hint_err)
    );

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_rdata == '0);
    p_ro_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_idx == R_INT_ID) |=> regs[R_INT_ID] == $past(regs[R_INT_ID]));
    p_exc_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_idx == R_EXC_ADDR) |=> regs[R_EXC_ADDR][1] == 1'b0);
    p_ctl_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cc_ctl_err |-> $past(regs[R_CYC_CTL]) == 64'd1);
    p_fill_hint_r13: assert property (@(posedge clk) disable iff (!rst_n)
        dtb_fill |-> $past(regs[R_DPTE][HINT_LSB+1:HINT_LSB]) == 2'b00);
endmodule

// File: tb/test_ctl_reg_bank.sv
`timescale 1ns/1ps
module test_ctl_reg_bank;
    import crb_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
    logic [5:0] acc_idx = '0;
    logic [63:0] acc_wdata = '0, acc_rdata, inv_va, fill_tag, fill_pte;
    logic [6:0] inv_asn;
    logic acc_fault, dtb_inv_all, dtb_inv_proc, dtb_inv_addr;
    logic itb_inv_all, itb_inv_proc, itb_inv_addr, dtb_fill, fill_hint_err, cc_ctl_err;
    logic [8:0] pv;
    assign pv = {dtb_inv_all, dtb_inv_proc, dtb_inv_addr, itb_inv_all, itb_inv_proc,
                 itb_inv_addr, dtb_fill, fill_hint_err, cc_ctl_err};

    ctl_reg_bank i_ctl_reg_bank (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [63:0] shadow [64];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic bit b_rd(input int i);
        if (i < 25) return 1'b1;
        case (i)
            25, 26, 27, 28, 29, 30, 32, 33, 34, 35, 37, 38, 49, 50, 51: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit b_wr(input int i);
        return i <= 52 && i != 37 && i != 38;
    endfunction

    function automatic logic [63:0] b_next(input int i, input logic [63:0] d);
        case (i)
            25: return d & 64'hFFFF_FFFF_FFFF_FFFD;
            26, 27: return d & 64'hF;
            28: return d & 64'h1F;
            29, 30, 31: return d & 64'h18;
            32: return d & 64'h7FFF0;
            33, 34, 43, 44, 46, 47: return 64'd0;
            36: return 64'd1;
            49: return {d[63:57], 57'd0};
            50: return {53'd0, d[10:4], 4'd0};
            default: return d;
        endcase
    endfunction

    function automatic string tagof(input int i);
        if (i < 25) return "R2";
        case (i)
            25: return "R4";
            33, 34: return "R5";
            35: return "R8";
            37, 38: return "R6";
            51: return "R12";
            26, 27, 28, 29, 30, 32, 49, 50: return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic do_wr(input int i, input logic [63:0] d, output logic f, output logic [8:0] p);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_idx = 6'(i); acc_wdata = d;
        #1 f = acc_fault;
        @(posedge clk);
        #1 p = pv;
        acc_valid = 1'b0; acc_write = 1'b0;
        if (b_wr(i)) shadow[i] = b_next(i, d);
    endtask

    task automatic do_rd(input int i, output logic [63:0] d, output logic f, output time t);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_idx = 6'(i);
        #1 d = acc_rdata; f = acc_fault; t = $time;
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic idle_pv(input string tag);
        @(posedge clk);
        #1 chk(pv == 9'd0, tag, 64'(pv), 64'd0);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic f;
        logic [8:0] p;
        logic [63:0] d, d2, pte;
        time t1, t2;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 64; i++) shadow[i] = '0;

        repeat (3) @(posedge clk);
        #1 chk(pv == 9'd0, "R1 pulses in reset", 64'(pv), 64'd0);
        @(negedge clk) rst_n = 1'b1;

        // R1: every readable index reads zero after reset
        for (int i = 0; i < 64; i++) if (b_rd(i)) begin
            do_rd(i, d, f, t1);
            if (i == 35) chk(d[63:32] == 32'd0 && !f, "R1 reset counter high", d, 64'd0);
            else         chk(d == 64'd0 && !f, "R1 reset value", d, 64'd0);
        end

        // R9: write-once cycle control
        do_wr(36, 64'hDEAD, f, p);
        chk(!f && p == 9'd0, "R9 first write no error", 64'(p), 64'd0);
        do_wr(36, 64'h0, f, p);
        chk(!f && p == 9'd1, "R9 second write error", 64'(p), 64'd1);
        idle_pv("R9 error one cycle");
        do_rd(36, d, f, t1);
        chk(f && d == 0, "R7 read of cycle control faults", d, 64'd0);

        // R10: command pulses, each alone and for one cycle
        do_wr(43, 64'h5, f, p); chk(p == 9'b100000000, "R10 dtb all", 64'(p), 64'h100); idle_pv("R10 dtb all once");
        do_wr(44, 64'h5, f, p); chk(p == 9'b010000000, "R10 dtb proc", 64'(p), 64'h080); idle_pv("R10 dtb proc once");
        do_wr(46, 64'h5, f, p); chk(p == 9'b000100000, "R10 itb all", 64'(p), 64'h020); idle_pv("R10 itb all once");
        do_wr(47, 64'h5, f, p); chk(p == 9'b000010000, "R10 itb proc", 64'(p), 64'h010); idle_pv("R10 itb proc once");

        // R11: single-address invalidates carry their own side's ASN
        do_wr(49, {7'h55, 57'h1234}, f, p);
        do_wr(50, 64'hFFFF_0000_0000_0330, f, p);
        do_wr(45, 64'hCAFE_0000_1000_2000, f, p);
        chk(p == 9'b001000000, "R11 dtb addr pulse", 64'(p), 64'h040);
        chk(inv_va == 64'hCAFE_0000_1000_2000, "R11 dtb va", inv_va, 64'hCAFE_0000_1000_2000);
        chk(inv_asn == 7'h55, "R11 dtb asn", 64'(inv_asn), 64'h55);
        do_wr(48, 64'h0000_7777_0000_1111, f, p);
        chk(p == 9'b000001000, "R11 itb addr pulse", 64'(p), 64'h008);
        chk(inv_va == 64'h0000_7777_0000_1111, "R11 itb va", inv_va, 64'h0000_7777_0000_1111);
        chk(inv_asn == 7'h33, "R11 itb asn", 64'(inv_asn), 64'h33);

        // R13: fill from staged entry, refused on nonzero hint
        pte = 64'hFFFF_FFFF_FFFF_FF96;
        do_wr(51, pte, f, p);
        do_rd(51, d, f, t1);
        chk(d == (pte & 64'hFFFF_FFFF_0000_FF16), "R12 staged view", d, pte & 64'hFFFF_FFFF_0000_FF16);
        do_wr(52, 64'h0123_4567_89AB_CDEF, f, p);
        chk(p == 9'b000000100, "R13 fill pulse", 64'(p), 64'h004);
        chk(fill_tag == 64'h0123_4567_89AB_CDEF, "R13 fill tag", fill_tag, 64'h0123_4567_89AB_CDEF);
        d2 = (pte & 64'h07FF_FFFF_0000_FF16) | ({57'd0, 7'h55} << 57);
        chk(fill_pte == d2, "R13 fill entry", fill_pte, d2);
        do_wr(51, 64'h20, f, p);
        do_wr(52, 64'h77, f, p);
        chk(p == 9'b000000010, "R13 hint error no fill", 64'(p), 64'h002);
        idle_pv("R13 error one cycle");

        // R8: tick advances one per clock
        do_wr(35, 64'hABCD_0123_FFFF_FFFF, f, p);
        do_rd(35, d, f, t1);
        repeat (7) @(posedge clk);
        do_rd(35, d2, f, t2);
        chk(d2[63:32] == 32'hABCD_0123, "R8 stored high half", d2, 64'hABCD_0123_0000_0000);
        chk(64'(d2[31:0] - d[31:0]) == 64'((t2 - t1) / 8ns), "R8 tick step",
            64'(d2[31:0] - d[31:0]), 64'((t2 - t1) / 8ns));

        // R6: read-only write faults and leaves value
        do_wr(37, 64'hFFFF, f, p);
        chk(f, "R6 write fault", 64'(f), 64'd1);
        do_rd(37, d, f, t1);
        chk(d == 0 && !f, "R6 unchanged", d, 64'd0);

        // Sweep every index with fixed and random patterns (skip write-once index)
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 64; i++) begin
                logic [63:0] pat;
                case (k)
                    0: pat = '1;
                    1: pat = 64'hAAAA_AAAA_AAAA_AAAA;
                    2: pat = 64'h5555_5555_5555_5555;
                    default: pat = {$urandom, $urandom};
                endcase
                if (i == 36) continue;
                do_wr(i, pat, f, p);
                chk(f == !b_wr(i), {tagof(i), " write fault"}, 64'(f), 64'(!b_wr(i)));
                do_rd(i, d, f, t1);
                chk(f == !b_rd(i), {tagof(i), " read fault"}, 64'(f), 64'(!b_rd(i)));
                d2 = b_rd(i) ? ((i == 51) ? (shadow[i] & 64'hFFFF_FFFF_0000_FF16) : shadow[i]) : 64'd0;
                if (i == 35) chk(d[63:32] == d2[63:32], "R8 read high", d, d2);
                else         chk(d == d2, {tagof(i), " read value"}, d, d2);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule